// File: doc/BRIEF.md
# Three-Product Split Multiplier (32x32 unsigned)

This block multiplies two unsigned 32-bit operands into a 64-bit product using only three narrow multipliers rather than four. Each operand is split into a high and a low 16-bit half. One 16x16 unit forms the product of the high halves and a second forms the product of the low halves. The halves of each operand are also summed into a 17-bit value, and a single 17x17 unit multiplies the two sums.

The middle term of the product equals the sum product minus both half products. It is found with 34-bit subtractors and is always non-negative. A 64-bit adder then places the high product 32 bits up, the middle term 16 bits up and the low product at bit zero. Any carry past bit 63 is dropped.

A caller presents both operands with an input valid strobe. The product register loads on that clock edge. The output valid strobe is high during the following cycle, and the product stays held until the next accepted operation.

Top module: `kmul_top`

## Requirements
- R1: For every accepted pair of operands, the output product one cycle later equals the full unsigned product of the two 32-bit operands, taken modulo 2^64.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high and low in the cycle after a cycle with `in_valid` low. This holds for single operations and for back-to-back streams.
- R3: While `rst` is high at a clock edge, `out_valid` and `prod_out` are cleared to zero after that edge, even if `in_valid` is high at the same time.
- R4: When `in_valid` is low, `prod_out` keeps its previous value no matter how `x_in` and `y_in` change.
- R5: The half-sums keep their carry as a 17th bit. When every half is all ones (0xFFFF), the product of 0xFFFFFFFF with itself comes out as 0xFFFFFFFE00000001.
- R6: The middle term never borrows. The sum product is at least the sum of the two half products, and the 34-bit middle term always has its top bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on `x_in`/`y_in` are accepted at this edge |
| x_in | input | 32 | First unsigned operand |
| y_in | input | 32 | Second unsigned operand |
| out_valid | output | 1 | `prod_out` holds a fresh result this cycle |
| prod_out | output | 64 | Registered unsigned product |

## Verification
A fault in a half-sum carry, in the width of a subtractor or in a combine shift shows up as a wrong product in the cycle right after the operation. Operands whose halves are all ones, or are zero in one half, drive each such carry path and make the error easy to see. A fault in the load enable or in the valid register appears as an extra or missing `out_valid` pulse on the next edge. It can also appear as a product that drifts while `in_valid` is low, and that drift is visible within one cycle of the change to the operands.

// File: rtl/kmul_pkg.sv
package kmul_pkg;
  localparam int KMUL_HALF_DEF = 16;

  function automatic int kmul_mid_width(input int half_w);
    return 2 * half_w + 2;
  endfunction
endpackage

// File: rtl/kmul_half_sum.sv
module kmul_half_sum #(
  parameter int HALF_W = 16,
  localparam int FW = 2 * HALF_W
) (
  input  logic [FW-1:0]   word,
  output logic [HALF_W:0] hsum
);
  always_comb begin
    hsum = {1'b0, word[FW-1:HALF_W]} + {1'b0, word[HALF_W-1:0]};
  end
endmodule

// File: rtl/kmul_sub_mult.sv
module kmul_sub_mult #(
  parameter int AW = 16,
  localparam int PW = 2 * AW
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic [PW-1:0] p
);
  always_comb begin
    p = {{AW{1'b0}}, a} * {{AW{1'b0}}, b};
  end
endmodule

// File: rtl/kmul_cross.sv
module kmul_cross #(
  parameter int HALF_W = 16,
  localparam int PP = 2 * HALF_W,
  localparam int MP = 2 * HALF_W + 2
) (
  input  logic [MP-1:0] p_sum,
  input  logic [PP-1:0] p_hi,
  input  logic [PP-1:0] p_lo,
  output logic [MP-1:0] mid
);
  always_comb begin
    mid = p_sum - {2'b00, p_hi} - {2'b00, p_lo};
  end
endmodule

// File: rtl/kmul_combine.sv
module kmul_combine #(
  parameter int HALF_W = 16,
  localparam int PP = 2 * HALF_W,
  localparam int MP = 2 * HALF_W + 2,
  localparam int OW = 4 * HALF_W
) (
  input  logic [PP-1:0] p_hi,
  input  logic [MP-1:0] mid,
  input  logic [PP-1:0] p_lo,
  output logic [OW-1:0] prod
);
  logic [OW-1:0] hi_ext, mid_ext, lo_ext;
  always_comb begin
    hi_ext  = {p_hi, {PP{1'b0}}};
    mid_ext = {{(OW-MP){1'b0}}, mid} << HALF_W;
    lo_ext  = {{PP{1'b0}}, p_lo};
    prod    = hi_ext + mid_ext + lo_ext;
  end
endmodule

// File: rtl/kmul_top.sv
module kmul_top #(
  parameter int HALF_W = kmul_pkg::KMUL_HALF_DEF,
  localparam int FW = 2 * HALF_W,
  localparam int HS = HALF_W + 1,
  localparam int PP = 2 * HALF_W,
  localparam int MP = kmul_pkg::kmul_mid_width(HALF_W),
  localparam int OW = 4 * HALF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [FW-1:0] x_in,
  input  logic [FW-1:0] y_in,
  output logic          out_valid,
  output logic [OW-1:0] prod_out
);
  logic [HS-1:0] xs_w, ys_w;
  logic [PP-1:0] phh_w, pll_w;
  logic [MP-1:0] psum_w, mid_w;
  logic [OW-1:0] prod_w;

  kmul_half_sum #(.HALF_W(HALF_W)) u_xsum (.word(x_in), .hsum(xs_w));
  kmul_half_sum #(.HALF_W(HALF_W)) u_ysum (.word(y_in), .hsum(ys_w));

  kmul_sub_mult #(.AW(HALF_W)) u_mul_hi (
    .a(x_in[FW-1:HALF_W]), .b(y_in[FW-1:HALF_W]), .p(phh_w));
  kmul_sub_mult #(.AW(HALF_W)) u_mul_lo (
    .a(x_in[HALF_W-1:0]), .b(y_in[HALF_W-1:0]), .p(pll_w));
  kmul_sub_mult #(.AW(HS)) u_mul_sum (
    .a(xs_w), .b(ys_w), .p(psum_w));

  kmul_cross #(.HALF_W(HALF_W)) u_cross (
    .p_sum(psum_w), .p_hi(phh_w), .p_lo(pll_w), .mid(mid_w));

  kmul_combine #(.HALF_W(HALF_W)) u_comb (
    .p_hi(phh_w), .mid(mid_w), .p_lo(pll_w), .prod(prod_w));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      prod_out  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) prod_out <= prod_w;
    end
  end

  // R2: valid strobe tracks the input strobe by one cycle
  a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R4: product held while idle
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(prod_out));
  // R1: product parity bit follows the operand low bits
  a_r1_lsb: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (prod_out[0] == $past(x_in[0] & y_in[0])));
  // R6: middle term free of borrow
  a_r6_no_borrow: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (mid_w[MP-1] == 1'b0));
  a_r6_sum_dominates: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (psum_w >= ({2'b00, phh_w} + {2'b00, pll_w})));
endmodule

// File: tb/tb_kmul_top.sv
module tb_kmul_top;
  localparam int CLK_P = 10;
  localparam int NCORN = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] x_in = '0, y_in = '0;
  logic        out_valid;
  logic [63:0] prod_out;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  kmul_top dut (.clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in),
                .y_in(y_in), .out_valid(out_valid), .prod_out(prod_out));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    return {32'h0, a} * {32'h0, b};
  endfunction

  function automatic logic [31:0] corner(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_FFFF;
      4: return 32'hFFFF_0000;
      5: return 32'h8000_0000;
      6: return 32'h0001_0001;
      default: return 32'h7FFF_8000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [31:0] lfsr = 32'h1234_5678;
  task automatic step_lfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  // streaming: operands at each negedge, result checked at the next negedge
  task automatic run_pair(input logic [31:0] a, input logic [31:0] b, input string req);
    in_valid = 1'b1; x_in = a; y_in = b;
    @(negedge clk);
    chk(req, prod_out, ref_mul(a, b));
    chk("R2 valid after accept", {63'h0, out_valid}, 64'h1);
  endtask

  initial begin
    logic [63:0] held;
    repeat (2) @(negedge clk);
    chk("R3 reset valid", {63'h0, out_valid}, 64'h0);
    chk("R3 reset product", prod_out, 64'h0);
    rst = 1'b0;

    // R5 all-ones halves
    run_pair(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 all-ones");
    chk("R5 literal", prod_out, 64'hFFFF_FFFE_0000_0001);

    // R1 corner cross product, back-to-back
    for (int i = 0; i < NCORN; i++)
      for (int j = 0; j < NCORN; j++)
        run_pair(corner(i), corner(j), "R1 corner");

    // R1 pseudo-random stream
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] a;
      step_lfsr(); a = lfsr;
      step_lfsr();
      run_pair(a, lfsr, "R1 random");
    end

    // R4 idle with changing operands, R2 valid falls
    in_valid = 1'b0;
    held = prod_out;
    for (int k = 0; k < 4; k++) begin
      step_lfsr(); x_in = lfsr; y_in = ~lfsr;
      @(negedge clk);
      chk("R4 hold", prod_out, held);
      chk("R2 valid low", {63'h0, out_valid}, 64'h0);
    end

    // R2 isolated pulse
    run_pair(32'h0001_2345, 32'hABCD_0001, "R1 single");
    in_valid = 1'b0;
    @(negedge clk);
    chk("R2 single pulse end", {63'h0, out_valid}, 64'h0);

    // R6 half-sum carry stress: both halves large
    run_pair(32'hFFFF_8001, 32'h8001_FFFF, "R6 carry mix");
    run_pair(32'hFFFE_FFFF, 32'hFFFF_FFFE, "R6 near max");

    // R3 reset wins over valid
    rst = 1'b1;
    run_pair_reset: begin
      x_in = 32'hDEAD_BEEF; y_in = 32'h1234_5678; in_valid = 1'b1;
      @(negedge clk);
      chk("R3 reset over valid, valid", {63'h0, out_valid}, 64'h0);
      chk("R3 reset over valid, product", prod_out, 64'h0);
    end
    rst = 1'b0;
    run_pair(32'hDEAD_BEEF, 32'h1234_5678, "R1 after reset");
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule